// File: doc/BRIEF.md
# Serial Switch Register Access Master

This block lets on-chip logic read and write the 16-bit configuration registers of an Ethernet switch over a three-wire serial link (chip select, serial clock, data). A host raises `req_i` for one cycle with a direction flag, a register address and, for writes, the data. The block then builds the matching command frame. It shifts the frame out most significant bit first at a slow bit rate set by a prescaler, turns the data line around for reads and collects the reply. It finishes with trailing idle clocks and then releases all three wires.

The two directions use different frames. A read runs with chip select low. It opens with a long run of ones, then sends a short command carrying a 7-bit address, then receives a 32-bit word that holds a pair of registers. Address parity selects one half of that word. A write raises chip select and sends a 27-bit command that carries an 8-bit address and the 16 data bits. Every clock level and every data setup time is counted in system clock cycles, so the minimum serial timing holds at any system clock frequency.

Top module: `swcfg_serial_master`

## Requirements
- R1: Out of reset and whenever idle, `busy_o`=0, `done_o`=0, the three output enables are 0, and after reset `rdata_o`=0.
- R2: A request in an idle cycle is accepted at the next clock edge: `busy_o` rises, and for PHASE_CYC cycles chip select, clock and data are all driven to 0.
- R3: A read (`we_i`=0) sends 46 bits MSB first: 32 ones, then 0,1, then 1,0, then 0, then 0,0, then `addr_i[6:0]` MSB first.
- R4: Chip select stays 0 for an entire read. During a write it is 1 from the end of the first phase until the end of the low phase that follows the last command bit.
- R5: After a read command the data enable drops to 0 and two clock pulses follow, then one low phase. Then 32 bits are received MSB first. Each bit is sampled, through a two-flop synchronizer, in the last cycle of its low phase.
- R6: For a read, `rdata_o` takes bits 31..16 of the received word when `addr_i[0]`=1, and bits 15..0 when `addr_i[0]`=0.
- R7: A write (`we_i`=1) sends 27 bits MSB first: 1, then 0,1, then `addr_i[7:0]`, then `wdata_i[15:0]`.
- R8: After the command bits of a write, and after the received bits of a read, the clock is held low for one phase and chip select goes to 0. Then two extra pulses (PHASE_CYC high, PHASE_CYC low) are given with chip select 0.
- R9: Each command bit takes a low phase of PHASE_CYC cycles holding the previous data value. The new bit is then driven for SETUP_CYC cycles with the clock still low. The clock is then high for PHASE_CYC cycles. Data never changes while the clock is high.
- R10: In the cycle after the last extra pulse ends, `busy_o` falls, all enables fall and `done_o` is 1 for exactly one cycle. `rdata_o` is updated by reads only.
- R11: A request while `busy_o`=1 is ignored: the running frame, its timing and `rdata_o` are unaffected, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address (reads use bits 6..0) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with `done_o` after a read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| cs_o | output | 1 | Chip select value |
| cs_oe_o | output | 1 | Chip select drive enable |
| sck_o | output | 1 | Serial clock value |
| sck_oe_o | output | 1 | Serial clock drive enable |
| sd_o | output | 1 | Serial data value |
| sd_oe_o | output | 1 | Serial data drive enable |
| sd_i | input | 1 | Serial data from the switch |

## Verification
`busy_o` and the first all-low phase appear one cycle after the accepting edge. Every later phase lasts exactly PHASE_CYC or SETUP_CYC cycles. `done_o` and the release of the wires come in the cycle after the last extra low phase, and the read word is fixed two cycles after the reply bit is presented, by the last cycle of each low phase. The bench expands every request into a per-cycle list of expected wire states, derived from the frame and phase rules. It pops one entry each cycle and compares at the falling edge. It drives the reply bit at the first cycle of each receive low phase, so the synchronizer latency is covered.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;
  localparam int REG_W     = 16;
  localparam int RD_DATA_W = 2 * REG_W;
  localparam int PRE_ONES  = 32;
  localparam int RD_CMD_W  = PRE_ONES + 14;
  localparam int WR_CMD_W  = 27;
  localparam int FRAME_W   = (RD_CMD_W > WR_CMD_W) ? RD_CMD_W : WR_CMD_W;
  localparam int BC_W      = $clog2(FRAME_W + 1);
  localparam int PULSES    = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_CSUP, ST_TX_LO, ST_TX_SU, ST_TX_HI, ST_TX_END,
    ST_TRN_HI, ST_TRN_LO, ST_RX_LEAD, ST_RX_LO, ST_RX_HI, ST_RX_END,
    ST_XT_HI, ST_XT_LO
  } sm_e;
endpackage

// File: rtl/swcfg_phase_timer.sv
module swcfg_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/swcfg_sync2.sv
module swcfg_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/swcfg_frame_build.sv
module swcfg_frame_build
  import swcfg_pkg::*;
(
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [BC_W-1:0]  nbits_o
);
  localparam int RD_PAD = FRAME_W - RD_CMD_W;
  localparam int WR_PAD = FRAME_W - WR_CMD_W;

  logic [RD_CMD_W-1:0] rd_cmd;
  logic [WR_CMD_W-1:0] wr_cmd;

  // read: preamble, start 01, opcode 10, T=0, device 00, 7-bit address
  assign rd_cmd = {{PRE_ONES{1'b1}}, 2'b01, 2'b10, 1'b0, 2'b00, addr_i[6:0]};
  // write: start 1, opcode 01, 8-bit address, 16-bit data
  assign wr_cmd = {1'b1, 2'b01, addr_i, wdata_i};

  generate
    if (RD_PAD > 0) begin : g_rd_pad
      logic [FRAME_W-1:0] rd_al;
      assign rd_al = {rd_cmd, {RD_PAD{1'b0}}};
      assign frame_o = we_i ? {wr_cmd, {WR_PAD{1'b0}}} : rd_al;
    end else begin : g_rd_full
      assign frame_o = we_i ? {wr_cmd, {WR_PAD{1'b0}}} : rd_cmd;
    end
  endgenerate

  assign nbits_o = we_i ? BC_W'(WR_CMD_W) : BC_W'(RD_CMD_W);
endmodule

// File: rtl/swcfg_serial_master.sv
module swcfg_serial_master
  import swcfg_pkg::*;
#(
  parameter int PHASE_CYC = 375,
  parameter int SETUP_CYC = 125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_o,
  output logic             cs_oe_o,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic             sd_i
);
  localparam int TMAX  = (PHASE_CYC > SETUP_CYC) ? PHASE_CYC : SETUP_CYC;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int PW    = (PULSES > 1) ? $clog2(PULSES) : 1;

  sm_e state_q, state_d;
  logic                 we_q, odd_q, cs_q, sd_q, done_q;
  logic [FRAME_W-1:0]   frame_q, frame_w;
  logic [BC_W-1:0]      bit_cnt_q, nbits_w;
  logic [PW-1:0]        pulse_q;
  logic [RD_DATA_W-1:0] rx_q;
  logic [REG_W-1:0]     rdata_q;
  logic                 tmr_exp, tmr_start, sd_sync, pulse_last, bits_last;
  logic [CNT_W-1:0]     tmr_len;

  swcfg_frame_build i_frame (
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .frame_o(frame_w), .nbits_o(nbits_w)
  );

  swcfg_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start),
    .len_i(tmr_len), .expired_o(tmr_exp)
  );

  swcfg_sync2 i_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(sd_i), .q_o(sd_sync));

  assign pulse_last = (pulse_q == PW'(PULSES - 1));
  assign bits_last  = (bit_cnt_q == '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_PRE;
      ST_PRE:     state_d = ST_CSUP;
      ST_CSUP:    state_d = ST_TX_LO;
      ST_TX_LO:   state_d = ST_TX_SU;
      ST_TX_SU:   state_d = ST_TX_HI;
      ST_TX_HI:   state_d = bits_last ? ST_TX_END : ST_TX_LO;
      ST_TX_END:  state_d = we_q ? ST_XT_HI : ST_TRN_HI;
      ST_TRN_HI:  state_d = ST_TRN_LO;
      ST_TRN_LO:  state_d = pulse_last ? ST_RX_LEAD : ST_TRN_HI;
      ST_RX_LEAD: state_d = ST_RX_LO;
      ST_RX_LO:   state_d = ST_RX_HI;
      ST_RX_HI:   state_d = bits_last ? ST_RX_END : ST_RX_LO;
      ST_RX_END:  state_d = ST_XT_HI;
      ST_XT_HI:   state_d = ST_XT_LO;
      ST_XT_LO:   state_d = pulse_last ? ST_IDLE : ST_XT_HI;
      default:    state_d = ST_IDLE;
    endcase
    // timed states advance only on timer expiry
    if (state_q != ST_IDLE && !tmr_exp) state_d = state_q;
  end

  assign tmr_start = (state_q == ST_IDLE) ? req_i : (tmr_exp && state_d != ST_IDLE);
  assign tmr_len   = (state_d == ST_TX_SU) ? CNT_W'(SETUP_CYC) : CNT_W'(PHASE_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      odd_q     <= 1'b0;
      frame_q   <= '0;
      bit_cnt_q <= '0;
      pulse_q   <= '0;
      cs_q      <= 1'b0;
      sd_q      <= 1'b0;
      rx_q      <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_i) begin
          we_q      <= we_i;
          odd_q     <= addr_i[0];
          frame_q   <= frame_w;
          bit_cnt_q <= nbits_w - BC_W'(1);
          cs_q      <= 1'b0;
          sd_q      <= 1'b0;
        end
        ST_PRE:   if (tmr_exp) cs_q <= we_q;
        ST_TX_LO: if (tmr_exp) sd_q <= frame_q[FRAME_W-1];
        ST_TX_HI: if (tmr_exp) begin
          frame_q   <= {frame_q[FRAME_W-2:0], 1'b0};
          bit_cnt_q <= bits_last ? BC_W'(RD_DATA_W - 1) : bit_cnt_q - BC_W'(1);
        end
        ST_TX_END: if (tmr_exp) begin
          cs_q    <= 1'b0;
          pulse_q <= '0;
        end
        ST_TRN_LO: if (tmr_exp) pulse_q <= pulse_last ? '0 : pulse_q + PW'(1);
        ST_RX_LO:  if (tmr_exp) rx_q <= {rx_q[RD_DATA_W-2:0], sd_sync};
        ST_RX_HI:  if (tmr_exp && !bits_last) bit_cnt_q <= bit_cnt_q - BC_W'(1);
        ST_RX_END: if (tmr_exp) begin
          rdata_q <= odd_q ? rx_q[RD_DATA_W-1 -: REG_W] : rx_q[REG_W-1:0];
          pulse_q <= '0;
        end
        ST_XT_LO: if (tmr_exp) begin
          pulse_q <= pulse_last ? '0 : pulse_q + PW'(1);
          if (pulse_last) done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_TX_HI, ST_TRN_HI, ST_RX_HI, ST_XT_HI: sck_o = 1'b1;
      default:                                 sck_o = 1'b0;
    endcase
    case (state_q)
      ST_PRE, ST_CSUP, ST_TX_LO, ST_TX_SU, ST_TX_HI, ST_TX_END: sd_oe_o = 1'b1;
      ST_XT_HI, ST_XT_LO:                                       sd_oe_o = we_q;
      default:                                                  sd_oe_o = 1'b0;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign cs_oe_o  = busy_o;
  assign sck_oe_o = busy_o;
  assign cs_o     = cs_q;
  assign sd_o     = sd_q;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/swcfg_serial_master_chk.sv
module swcfg_serial_master_chk #(
  parameter int PHASE_CYC = 375,
  parameter int SETUP_CYC = 125
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_q_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_o,
  input logic cs_oe_o,
  input logic sck_o,
  input logic sck_oe_o,
  input logic sd_o,
  input logic sd_oe_o
);
  localparam int TMAX  = (PHASE_CYC > SETUP_CYC) ? PHASE_CYC : SETUP_CYC;
  localparam int AGE_W = $clog2(TMAX + 1) + 1;

  logic sck_prev, sd_prev;
  logic [AGE_W-1:0] sck_age, sd_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      sd_prev  <= 1'b0;
      sck_age  <= '0;
      sd_age   <= '0;
    end else begin
      sck_prev <= sck_o;
      sd_prev  <= sd_o;
      if (sck_o != sck_prev)  sck_age <= AGE_W'(1);
      else if (sck_age != '1) sck_age <= sck_age + AGE_W'(1);
      if (sd_o != sd_prev)    sd_age  <= AGE_W'(1);
      else if (sd_age != '1)  sd_age  <= sd_age + AGE_W'(1);
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(cs_oe_o || sck_oe_o || sd_oe_o)); // R1
  AST_START_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i)); // R2
  AST_READ_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !we_q_i) |-> !cs_o); // R4
  AST_CLK_LEVEL_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_o && sck_o != sck_prev) |-> sck_age >= AGE_W'(PHASE_CYC)); // R9
  AST_DATA_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && !sck_prev && sd_oe_o) |-> (sd_o == sd_prev && sd_age >= AGE_W'(SETUP_CYC))); // R9
  AST_DATA_CHANGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && sd_o != sd_prev) |-> !sck_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10
endmodule

bind swcfg_serial_master swcfg_serial_master_chk #(
  .PHASE_CYC(PHASE_CYC), .SETUP_CYC(SETUP_CYC)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_q_i(we_q),
  .busy_o(busy_o), .done_o(done_o), .cs_o(cs_o), .cs_oe_o(cs_oe_o),
  .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
);

// File: tb/test_swcfg_serial_master.sv
module test_swcfg_serial_master;
  localparam int P = 4;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req = 1'b0, we = 1'b0, sd_in = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy, done, cs, cs_oe, sck, sck_oe, sd, sd_oe;

  swcfg_serial_master #(.PHASE_CYC(P), .SETUP_CYC(S)) i_swcfg_serial_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done),
    .cs_o(cs), .cs_oe_o(cs_oe), .sck_o(sck), .sck_oe_o(sck_oe),
    .sd_o(sd), .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  // entry: {busy, done, cs_oe, cs, sck_oe, sck, sd_oe, sd, slave_bit}
  logic [8:0]  exp_q[$];
  int          tag_q[$];
  int          checks = 0, errors = 0;
  logic [15:0] exp_rdata = '0;
  logic        cur_sd = 1'b0;
  bit          finished = 1'b0;

  task automatic chk(int tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic push(int n, int tag, logic c, logic k, logic doe, logic d, logic sl);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b1, 1'b0, 1'b1, c, 1'b1, k, doe, d, sl});
      tag_q.push_back(tag);
    end
  endtask

  task automatic build(logic w, logic [7:0] a, logic [15:0] d, logic [31:0] word);
    logic [45:0] f;
    int n;
    if (w) begin
      f = {1'b1, 2'b01, a, d, 19'b0}; n = 27; // R7 write frame
    end else begin
      f = {32'hFFFF_FFFF, 2'b01, 2'b10, 1'b0, 2'b00, a[6:0]}; n = 46; // R3 read frame
    end
    cur_sd = 1'b0;
    push(P, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // R2 all low
    push(P, 4, w, 1'b0, 1'b1, 1'b0, 1'b0);     // R4 chip select level
    for (int i = 0; i < n; i++) begin
      logic b;
      b = f[45-i];
      push(P, 9, w, 1'b0, 1'b1, cur_sd, 1'b0); // R9 low phase holds old bit
      push(S, w ? 7 : 3, w, 1'b0, 1'b1, b, 1'b0);
      push(P, 9, w, 1'b1, 1'b1, b, 1'b0);
      cur_sd = b;
    end
    push(P, 8, w, 1'b0, 1'b1, cur_sd, 1'b0);   // R8 trailing low
    if (!w) begin
      for (int i = 0; i < 2; i++) begin        // R5 turnaround
        push(P, 5, 1'b0, 1'b1, 1'b0, cur_sd, 1'b0);
        push(P, 5, 1'b0, 1'b0, 1'b0, cur_sd, 1'b0);
      end
      push(P, 5, 1'b0, 1'b0, 1'b0, cur_sd, 1'b0);
      for (int i = 0; i < 32; i++) begin
        push(P, 5, 1'b0, 1'b0, 1'b0, cur_sd, word[31-i]);
        push(P, 5, 1'b0, 1'b1, 1'b0, cur_sd, word[31-i]);
      end
      push(P, 8, 1'b0, 1'b0, 1'b0, cur_sd, 1'b0);
      exp_rdata = a[0] ? word[31:16] : word[15:0]; // R6 parity select
    end
    for (int i = 0; i < 2; i++) begin          // R8 extra pulses
      push(P, 8, 1'b0, 1'b1, w, cur_sd, 1'b0);
      push(P, 8, 1'b0, 1'b0, w, cur_sd, 1'b0);
    end
    exp_q.push_back({1'b0, 1'b1, 7'b0});       // R10 done, released
    tag_q.push_back(10);
  endtask

  task automatic tick();
    logic [8:0] e;
    logic [7:0] act, expv;
    int t;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = '0; t = 1; // R1 idle
    end
    act  = {busy, done, cs_oe, cs, sck_oe, sck, sd_oe, e[2] ? sd : 1'b0};
    expv = {e[8:2], e[2] ? e[1] : 1'b0};
    chk(t, "wires {busy,done,cs_oe,cs,sck_oe,sck,sd_oe,sd}", 32'(act), 32'(expv));
    if (e[7]) chk(we ? 10 : 6, "rdata at done", 32'(rdata), 32'(exp_rdata));
    sd_in = e[0];
  endtask

  task automatic issue(logic w, logic [7:0] a, logic [15:0] d, logic [31:0] word);
    req = 1'b1; we = w; addr = a; wdata = d;
    build(w, a, d, word);
    tick();
    req = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "busy in reset", 32'(busy), 0);
    chk(1, "done in reset", 32'(done), 0);
    chk(1, "enables in reset", 32'({cs_oe, sck_oe, sd_oe}), 0);
    chk(1, "rdata in reset", 32'(rdata), 0);
    rst_n = 1'b1;
    repeat (3) tick();

    issue(1'b0, 8'h2B, 16'h0, 32'hA5C3_1E77);  // R6 odd -> upper
    drain();
    issue(1'b0, 8'h54, 16'h0, 32'h0F0F_8001);  // R6 even -> lower
    drain();
    repeat (2) tick();
    issue(1'b1, 8'hA7, 16'h5A3C, 32'h0);       // R7 write
    drain();
    issue(1'b1, 8'h00, 16'hFFFF, 32'h0);       // back to back, boundary data
    drain();
    issue(1'b0, 8'h7F, 16'h0, 32'hFFFF_0000);  // R3 top address
    drain();
    issue(1'b0, 8'h80, 16'h0, 32'h1234_C0DE);  // R3 bit 7 not in read frame
    drain();
    repeat (2) tick();

    // R11 request while busy ignored
    issue(1'b1, 8'h3C, 16'h8421, 32'h0);
    repeat (40) tick();
    req = 1'b1; we = 1'b0; addr = 8'h11; wdata = 16'hDEAD;
    tick();
    req = 1'b0;
    repeat (100) tick();
    req = 1'b1;
    tick();
    req = 1'b0;
    drain();
    chk(11, "rdata kept after write with ignored read", 32'(rdata), 32'(exp_rdata));
    repeat (5) tick();
    chk(11, "no second transaction", 32'(busy), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule